// File: doc/BRIEF.md
# Cycle-Timed Memory Reference Controller

This block sits between a microcoded processor and a small word-wide memory. A reference starts when the processor asks to load an address. A cycle counter then steps the reference through a fixed schedule. At set cycles the controller captures the addressed word and its companion word into two data latches. The companion word lives at the same address with bit 0 inverted. Stores are taken only inside a fixed window, and a second store in the same reference goes to the companion word.

The controller reports three ready signals: one for starting a reference, one for reading the data latch, and one for storing. The processor holds its current microinstruction while it requests an operation whose ready signal is low. A store that arrives while its ready signal is high but outside the store window is not performed. It raises an error pulse instead. Read results stay available after the reference ends. The first read in the cycle right after the end returns the companion word, which completes a double-word read.

Cycle numbering: the clock edge that accepts an address request moves the reference to cycle 1. Each later edge adds one, up to cycle 5, which is the last active cycle. The edge after cycle 5 leaves a one-cycle tail, called cycle 6, in which the controller is idle. After the tail it is idle again with no reference.

Top module: `mem_ref_ctrl`

## Requirements
- R1: After reset, `rdy_lda`, `rdy_rd` and `rdy_st` are 1, `err` is 0, and `rd_data` is 0.
- R2: An address request made while `rdy_lda` is 1 is accepted. `rdy_lda` is then 0 for cycles 1 to 5 and is 1 again from cycle 6.
- R3: During a reference, `rdy_st` is 0 in cycles 1 and 2 and is 1 in cycles 3 to 5. `rdy_rd` is 0 in cycles 1 to 4 and is 1 in cycle 5.
- R4: A read in cycle 5 returns the word held at the latched address before any store made in that reference.
- R5: A read in the tail cycle 6 returns the pre-reference word at the latched address with bit 0 inverted. A read at any later idle cycle returns the pre-reference word at the latched address.
- R6: A store in cycle 3 writes `st_data` to the latched address. A store in cycle 4 writes to the address with bit 0 inverted if a cycle-3 store happened in the same reference, and to the latched address otherwise.
- R7: A store request made while `rdy_st` is 1 but outside cycles 3 and 4 (cycle 5 or idle) writes nothing. It sets `err` to 1 for the following cycle only.
- R8: `rd_data` is 0 in any cycle where `rd_req` and `rdy_rd` are not both 1.
- R9: An address request made during an active reference is ignored. The latched address and the cycle schedule do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lda_req | input | 1 | Request to load an address and start a reference |
| lda_addr | input | ADDR_W | Word address for the reference |
| rd_req | input | 1 | Request to read the memory data latch |
| st_req | input | 1 | Request to store a word |
| st_data | input | DATA_W | Word to store |
| rdy_lda | output | 1 | An address request can be accepted now |
| rdy_rd | output | 1 | A read can be served now |
| rdy_st | output | 1 | A store can be presented now |
| rd_data | output | DATA_W | Read result; 0 unless a read is being served |
| err | output | 1 | One-cycle pulse after a store outside its window |

## Verification
The bench builds the block with ADDR_W set to 6, which gives a 64-word array. With so few words, random references keep landing on addresses that were written earlier, at both even and odd parity of bit 0. This exercises stores to the companion word and reads that must see the values from before the current reference. DATA_W stays at 16, so random store words cover the full word width.

// File: rtl/mem_ref_ctrl.sv
module mem_ref_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lda_req,
  input  logic [ADDR_W-1:0] lda_addr,
  input  logic              rd_req,
  input  logic              st_req,
  input  logic [DATA_W-1:0] st_data,
  output logic              rdy_lda,
  output logic              rdy_rd,
  output logic              rdy_st,
  output logic [DATA_W-1:0] rd_data,
  output logic              err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [2:0] C_FIRST = 3'd1;
  localparam logic [2:0] C_CAP1  = 3'd2;
  localparam logic [2:0] C_ST1   = 3'd3;
  localparam logic [2:0] C_ST2   = 3'd4;
  localparam logic [2:0] C_LAST  = 3'd5;
  localparam logic [2:0] C_TAIL  = 3'd6;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr;
  logic [2:0]        cyc;
  logic              active, dw;
  logic [DATA_W-1:0] lat1, lat2;

  wire [ADDR_W-1:0] pair    = {addr[ADDR_W-1:1], ~addr[0]};
  wire              st_win  = active && (cyc == C_ST1 || cyc == C_ST2);
  wire              st_go   = st_req && st_win;
  wire              st_bad  = st_req && rdy_st && !st_win;
  wire [ADDR_W-1:0] st_addr = (cyc == C_ST2 && dw) ? pair : addr;

  assign rdy_lda = !active;
  assign rdy_rd  = !active || cyc == C_LAST;
  assign rdy_st  = !active || cyc >= C_ST1;
  assign rd_data = (rd_req && rdy_rd) ? ((cyc == C_TAIL) ? lat2 : lat1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      cyc    <= '0;
      active <= 1'b0;
      dw     <= 1'b0;
      lat1   <= '0;
      lat2   <= '0;
      err    <= 1'b0;
    end else begin
      err <= st_bad;
      if (active) begin
        cyc <= cyc + 3'd1;
        if (cyc == C_CAP1) lat1 <= mem[addr];
        if (cyc == C_ST1) begin
          lat2 <= mem[pair];
          if (st_req) dw <= 1'b1;
        end
        if (cyc == C_LAST) begin
          active <= 1'b0;
          dw     <= 1'b0;
        end
      end else if (lda_req) begin
        addr   <= lda_addr;
        active <= 1'b1;
        cyc    <= C_FIRST;
        dw     <= 1'b0;
      end else if (cyc == C_TAIL) begin
        cyc <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st_go) mem[st_addr] <= st_data;
  end

  a_r2_lda_taken: assert property (@(posedge clk) disable iff (!rst_n)
    lda_req && rdy_lda |=> !rdy_lda);
  a_r2_ref_holds: assert property (@(posedge clk) disable iff (!rst_n)
    active && cyc != C_LAST |=> active);
  a_r2_ref_ends: assert property (@(posedge clk) disable iff (!rst_n)
    active && cyc == C_LAST |=> rdy_lda && cyc == C_TAIL);
  a_r3_store_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_rd |-> rdy_st);
  a_r5_tail_single: assert property (@(posedge clk) disable iff (!rst_n)
    cyc == C_TAIL |=> cyc != C_TAIL);
  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(st_req));
  a_r9_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(addr));
endmodule

// File: tb/mem_ref_ctrl_bench.sv
`timescale 1ns/100ps
module mem_ref_ctrl_bench;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lda_req = 1'b0, rd_req = 1'b0, st_req = 1'b0;
  logic [AW-1:0] lda_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic rdy_lda, rdy_rd, rdy_st, err;
  logic [DW-1:0] rd_data;

  mem_ref_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_mem_ref_ctrl (
    .clk(clk), .rst_n(rst_n), .lda_req(lda_req), .lda_addr(lda_addr),
    .rd_req(rd_req), .st_req(st_req), .st_data(st_data),
    .rdy_lda(rdy_lda), .rdy_rd(rdy_rd), .rdy_st(rdy_st),
    .rd_data(rd_data), .err(err));

  always #2 clk = ~clk;

  int total = 0, fails = 0, wd = 0;
  bit done = 0;
  logic [DW-1:0] mir [N];
  logic [DW-1:0] last1 = '0;

  function automatic logic [AW-1:0] partner(input logic [AW-1:0] a);
    return {a[AW-1:1], ~a[0]};
  endfunction

  function automatic logic [AW-1:0] st4_target(input logic [AW-1:0] a, input bit had3);
    return had3 ? partner(a) : a;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input bit l, input logic [AW-1:0] la, input bit r, input bit s, input logic [DW-1:0] sd);
    @(negedge clk);
    lda_req = l; lda_addr = la; rd_req = r; st_req = s; st_data = sd;
    #0.5;
  endtask

  task automatic run_ref(input logic [AW-1:0] a, input bit s3, input bit s4, input bit r5,
                         input bit r6, input bit rl, input bit ld2, input bit s5,
                         input logic [DW-1:0] v3, input logic [DW-1:0] v4);
    logic [DW-1:0] p1, p2;
    p1 = mir[a];
    p2 = mir[partner(a)];
    drive(1, a, 0, 0, '0);
    chk(rdy_lda == 1'b1, "R2 idle accepts", {15'd0, rdy_lda}, 16'd1);
    drive(ld2, a ^ 6'd5, 0, 0, '0);
    chk(!rdy_lda && !rdy_st && !rdy_rd, "R3 cycle1 readies", {13'd0, rdy_lda, rdy_st, rdy_rd}, 16'd0);
    drive(0, '0, 0, 0, '0);
    chk(!rdy_lda && !rdy_st && !rdy_rd, "R3 cycle2 readies", {13'd0, rdy_lda, rdy_st, rdy_rd}, 16'd0);
    drive(0, '0, r5, s3, v3);
    chk(rdy_st && !rdy_rd && !rdy_lda, "R3 cycle3 readies", {13'd0, rdy_lda, rdy_st, rdy_rd}, 16'd2);
    chk(rd_data == '0, "R8 stalled read quiet", rd_data, '0);
    drive(0, '0, 0, s4, v4);
    chk(rdy_st && !rdy_rd, "R3 cycle4 readies", {14'd0, rdy_st, rdy_rd}, 16'd2);
    drive(0, '0, r5, s5, 16'hdead);
    chk(rdy_st && rdy_rd && !rdy_lda, "R3 cycle5 readies", {13'd0, rdy_lda, rdy_st, rdy_rd}, 16'd3);
    if (r5) chk(rd_data == p1, "R4 cycle5 read (R9 when retried)", rd_data, p1);
    else chk(rd_data == '0, "R8 no read quiet", rd_data, '0);
    drive(0, '0, r6, 0, '0);
    chk(rdy_lda && rdy_rd && rdy_st, "R2 ready after end", {13'd0, rdy_lda, rdy_st, rdy_rd}, 16'd7);
    chk(err == s5, "R7 err after late store", {15'd0, err}, {15'd0, s5});
    if (r6) chk(rd_data == p2, "R5 tail read partner", rd_data, p2);
    drive(0, '0, rl, 0, '0);
    chk(err == 1'b0, "R7 err one cycle", {15'd0, err}, 16'd0);
    if (rl) chk(rd_data == p1, "R5 late read first word", rd_data, p1);
    if (s3) mir[a] = v3;
    if (s4) mir[st4_target(a, s3)] = v4;
    last1 = p1;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", wd);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < N; i++) mir[i] = '0;
    repeat (3) @(posedge clk);
    #0.5;
    chk(rdy_lda && rdy_rd && rdy_st && !err, "R1 reset readies", {12'd0, rdy_lda, rdy_rd, rdy_st, err}, 16'he);
    @(negedge clk); rst_n = 1'b1; #0.5;
    chk(rd_data == '0, "R1 reset data", rd_data, '0);
    for (int a = 0; a < N; a += 2) begin
      logic [DW-1:0] w0, w1;
      w0 = DW'($urandom); w1 = DW'($urandom);
      run_ref(AW'(a), 1, 1, 0, 0, 0, 0, 0, w0, w1);
    end
    run_ref(6'd9, 0, 1, 1, 1, 1, 0, 0, '0, 16'h1234);
    run_ref(6'd9, 0, 0, 1, 1, 1, 0, 0, '0, '0);
    chk(mir[9] == 16'h1234, "R6 lone cycle4 store plain address", mir[9], 16'h1234);
    run_ref(6'd20, 1, 0, 1, 1, 1, 1, 1, 16'hbeef, '0);
    run_ref(6'd20, 0, 0, 1, 1, 1, 0, 0, '0, '0);
    drive(0, '0, 0, 1, 16'hffff);
    chk(rdy_st == 1'b1, "R7 idle store ready", {15'd0, rdy_st}, 16'd1);
    drive(0, '0, 1, 0, '0);
    chk(err == 1'b1, "R7 idle store err", {15'd0, err}, 16'd1);
    chk(rd_data == last1, "R5 idle read after stray store", rd_data, last1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_ref(AW'($urandom % N), r[0], r[1], r[2], r[3], r[4], r[5], r[6] & r[7],
              DW'($urandom), DW'($urandom));
    end
    for (int a = 0; a < N; a += 2) run_ref(AW'(a), 0, 0, 1, 1, 1, 0, 0, '0, '0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule